// File: doc/BRIEF.md
# Asynchronous Memory Bus Access Sequencer

This block runs a single read or write cycle on an external parallel memory bus. The bus shares its lines between address and data, and an address latch strobe marks the address. On the internal side, a one-cycle start pulse carries the address, the write data and the direction. The block accepts the pulse only while it is idle. When the cycle is over it returns a one-cycle done pulse, and for a read it also returns the data it captured.

On the external side, the block drives the shared address/data lines and their output enable, a narrow address port for the non-multiplexed mode, and four control lines: latch strobe, read strobe, write strobe and chip select. Configuration inputs set the bus mode, an independent polarity for each control line, the two address-phase counts, and the setup, strobe and hold counts for reads and for writes. These inputs must stay stable while an access is running.

Top module: `membus_seq`

## Requirements
- R1: A start pulse is accepted only when the sequencer is idle. A start pulse during an access, including its done cycle, has no effect on that access or on any later output.
- R2: In the multiplexed modes (mode 1: 16-bit data with 16-bit address; mode 2, and mode 3 treated the same way: 8-bit data with 24-bit address), the access begins with an address phase. During this phase chip select is active and the shared lines carry the address, 16 low bits in mode 1 and 24 bits otherwise, with the output enable high. The latch strobe first stays inactive for max(address-hold count, 1) cycles. It is then active for address-setup count + 1 cycles.
- R3: In mode 0 (8-bit data with 8-bit address, not multiplexed), there is no address phase and the latch strobe never becomes active. The narrow address port carries address bits 7:0 while chip select is active. In every other mode, and whenever chip select is inactive, that port reads zero.
- R4: The setup phase lasts exactly the setup count of the access direction. During it, chip select is active and both strobes are inactive. A count of 0 removes the phase.
- R5: The strobe phase activates the read strobe for a read, or the write strobe for a write, for max(strobe count, 1) cycles of that direction.
- R6: The hold phase keeps chip select active, with both strobes inactive, for exactly the hold count of the access direction. A count of 0 removes the phase.
- R7: The cycle after the last active phase is the done cycle. In it, the done output is high for exactly one cycle and all control lines are inactive. The sequencer is idle in the following cycle.
- R8: On a write, the output enable is high from the first setup cycle through the last hold cycle. The shared lines carry the write data during that span: all 16 bits in mode 1, and bits 7:0 zero-extended in the other modes.
- R9: On a read, the output enable is low from the setup phase onward. The read data is the value on the input lines in the last strobe cycle: 16 bits in mode 1, and bits 7:0 zero-extended otherwise. It stays unchanged until a later read reaches the end of its strobe.
- R10: Each control line has its own polarity bit: bit 0 for the latch strobe, bit 1 for the read strobe, bit 2 for the write strobe and bit 3 for chip select. A bit value of 1 makes the line active-high, and 0 makes it active-low.
- R11: After reset, every control line is at its inactive level, and the output enable, done, read data and narrow address port are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_start_i | input | 1 | One-cycle access request |
| req_write_i | input | 1 | 1 = write, 0 = read |
| req_addr_i | input | AW (24) | Access address |
| req_wdata_i | input | DW (16) | Write data |
| rsp_done_o | output | 1 | One-cycle completion pulse |
| rsp_rdata_o | output | DW (16) | Captured read data |
| cfg_mode_i | input | 2 | Bus mode, 0 to 3 |
| cfg_pol_i | input | 4 | Per-line polarity (1 = active-high) |
| cfg_adr_hold_i | input | SW (2) | Cycles address is driven before the latch strobe (0 means 1) |
| cfg_adr_setup_i | input | SW (2) | Extra latch-strobe cycles |
| cfg_rd_setup_i | input | SW (2) | Read setup cycles |
| cfg_rd_strobe_i | input | TW (4) | Read strobe cycles (0 means 1) |
| cfg_rd_hold_i | input | SW (2) | Read hold cycles |
| cfg_wr_setup_i | input | SW (2) | Write setup cycles |
| cfg_wr_strobe_i | input | TW (4) | Write strobe cycles (0 means 1) |
| cfg_wr_hold_i | input | SW (2) | Write hold cycles |
| bus_ad_o | output | BW (24) | Shared address/data lines, outgoing |
| bus_ad_i | input | DW (16) | Shared data lines, incoming |
| bus_oe_o | output | 1 | Drive enable for bus_ad_o |
| bus_addr_o | output | NW (8) | Address lines for the non-multiplexed mode |
| bus_ale_o | output | 1 | Address latch strobe |
| bus_re_o | output | 1 | Read strobe |
| bus_we_o | output | 1 | Write strobe |
| bus_cs_o | output | 1 | Chip select |

## Verification
Call the cycle right after the clock edge that accepts a start pulse cycle 0. Phase k then begins at the sum of the lengths of all earlier phases, and the done pulse falls at the sum of all phase lengths. The driver task computes these phase lengths from the requirements for each configuration. It tags every expected cycle with its absolute cycle number, and the monitor compares that expectation against the outputs at the falling edge of exactly that cycle. The incoming data changes every cycle. A read therefore passes only if it was captured in the last strobe cycle. One further checked cycle after the done cycle shows the value being held.

// File: rtl/membus_pkg.sv
package membus_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_AHOLD,
    ST_ASETUP,
    ST_SETUP,
    ST_STROBE,
    ST_HOLD,
    ST_DONE
  } seq_state_e;

  // control line slots; the polarity vector uses the same positions
  localparam int LN_ALE   = 0;
  localparam int LN_RE    = 1;
  localparam int LN_WE    = 2;
  localparam int LN_CS    = 3;
  localparam int LN_COUNT = 4;

  localparam logic [1:0] MODE_D8A8   = 2'd0;
  localparam logic [1:0] MODE_D16A16 = 2'd1;

endpackage

// File: rtl/membus_cnt.sv
module membus_cnt #(
  parameter int W = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load_i,
  input  logic [W-1:0] val_i,
  output logic         zero_o
);

  logic [W-1:0] cnt_q;
  logic [W-1:0] cnt_d;
  logic         cnt_en;

  always_comb begin
    cnt_en = load_i || (cnt_q != '0);
    cnt_d  = load_i ? val_i : (cnt_q - W'(1));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  assign zero_o = (cnt_q == '0);

  // R5: an idle counter never wraps below zero
  a_r5_cnt_no_wrap: assert property (@(posedge clk) disable iff (!rst_n)
    (!load_i && cnt_q == '0) |=> (cnt_q == '0));

endmodule

// File: rtl/membus_pol.sv
module membus_pol #(
  parameter int N = 4
) (
  input  logic [N-1:0] act_i,
  input  logic [N-1:0] pol_i,
  output logic [N-1:0] pin_o
);

  for (genvar g = 0; g < N; g++) begin : g_line
    assign pin_o[g] = pol_i[g] ? act_i[g] : ~act_i[g];
  end

endmodule

// File: rtl/membus_seq.sv
module membus_seq
  import membus_pkg::*;
#(
  parameter  int AW  = 24,
  parameter  int DW  = 16,
  parameter  int NW  = 8,
  parameter  int MAW = 16,
  parameter  int SW  = 2,
  parameter  int TW  = 4,
  localparam int BW  = (AW > DW) ? AW : DW
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req_start_i,
  input  logic          req_write_i,
  input  logic [AW-1:0] req_addr_i,
  input  logic [DW-1:0] req_wdata_i,
  output logic          rsp_done_o,
  output logic [DW-1:0] rsp_rdata_o,
  input  logic [1:0]    cfg_mode_i,
  input  logic [3:0]    cfg_pol_i,
  input  logic [SW-1:0] cfg_adr_hold_i,
  input  logic [SW-1:0] cfg_adr_setup_i,
  input  logic [SW-1:0] cfg_rd_setup_i,
  input  logic [TW-1:0] cfg_rd_strobe_i,
  input  logic [SW-1:0] cfg_rd_hold_i,
  input  logic [SW-1:0] cfg_wr_setup_i,
  input  logic [TW-1:0] cfg_wr_strobe_i,
  input  logic [SW-1:0] cfg_wr_hold_i,
  output logic [BW-1:0] bus_ad_o,
  input  logic [DW-1:0] bus_ad_i,
  output logic          bus_oe_o,
  output logic [NW-1:0] bus_addr_o,
  output logic          bus_ale_o,
  output logic          bus_re_o,
  output logic          bus_we_o,
  output logic          bus_cs_o
);

  // reset: asserted asynchronously, released on the clock
  logic [1:0] rst_sync_q;
  logic       rst_s_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= '0;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_s_n = rst_sync_q[1];

  seq_state_e    state_q, state_d, succ;
  logic          advance, cnt_zero, accept, rd_capture;
  logic          wr_eff, mux_eff;
  logic [SW-1:0] t_setup, t_hold;
  logic [TW-1:0] t_strobe, load_val;

  logic          wr_q, mux_q, mode16_q;
  logic [AW-1:0] addr_q;
  logic [DW-1:0] wdata_q, rdata_q;

  // next state: walk the phase list, skipping phases of zero length
  always_comb begin
    wr_eff   = (state_q == ST_IDLE) ? req_write_i : wr_q;
    mux_eff  = (state_q == ST_IDLE) ? (cfg_mode_i != MODE_D8A8) : mux_q;
    t_setup  = wr_eff ? cfg_wr_setup_i  : cfg_rd_setup_i;
    t_strobe = wr_eff ? cfg_wr_strobe_i : cfg_rd_strobe_i;
    t_hold   = wr_eff ? cfg_wr_hold_i   : cfg_rd_hold_i;
    advance  = cnt_zero;
    succ     = ST_IDLE;
    unique case (state_q)
      ST_IDLE: begin
        advance = req_start_i;
        succ    = mux_eff ? ST_AHOLD : ((t_setup != '0) ? ST_SETUP : ST_STROBE);
      end
      ST_AHOLD:  succ = ST_ASETUP;
      ST_ASETUP: succ = (t_setup != '0) ? ST_SETUP : ST_STROBE;
      ST_SETUP:  succ = ST_STROBE;
      ST_STROBE: succ = (t_hold != '0) ? ST_HOLD : ST_DONE;
      ST_HOLD:   succ = ST_DONE;
      default: begin
        advance = 1'b1;
        succ    = ST_IDLE;
      end
    endcase
    state_d = advance ? succ : state_q;

    // counter preload = phase length - 1
    unique case (succ)
      ST_AHOLD:  load_val = (cfg_adr_hold_i == '0) ? '0 : TW'(cfg_adr_hold_i) - TW'(1);
      ST_ASETUP: load_val = TW'(cfg_adr_setup_i);
      ST_SETUP:  load_val = TW'(t_setup) - TW'(1);
      ST_STROBE: load_val = (t_strobe == '0) ? '0 : t_strobe - TW'(1);
      ST_HOLD:   load_val = TW'(t_hold) - TW'(1);
      default:   load_val = '0;
    endcase
  end

  assign accept     = (state_q == ST_IDLE) && req_start_i;
  assign rd_capture = (state_q == ST_STROBE) && cnt_zero && !wr_q;

  always_ff @(posedge clk or negedge rst_s_n) begin
    if (!rst_s_n) state_q <= ST_IDLE;
    else          state_q <= state_d;
  end

  always_ff @(posedge clk or negedge rst_s_n) begin
    if (!rst_s_n) begin
      wr_q     <= 1'b0;
      mux_q    <= 1'b0;
      mode16_q <= 1'b0;
      addr_q   <= '0;
      wdata_q  <= '0;
    end else if (accept) begin
      wr_q     <= req_write_i;
      mux_q    <= (cfg_mode_i != MODE_D8A8);
      mode16_q <= (cfg_mode_i == MODE_D16A16);
      addr_q   <= req_addr_i;
      wdata_q  <= req_wdata_i;
    end
  end

  always_ff @(posedge clk or negedge rst_s_n) begin
    if (!rst_s_n)        rdata_q <= '0;
    else if (rd_capture) rdata_q <= mode16_q ? bus_ad_i : DW'(bus_ad_i[NW-1:0]);
  end

  membus_cnt #(.W(TW)) u_cnt (
    .clk    (clk),
    .rst_n  (rst_s_n),
    .load_i (advance),
    .val_i  (load_val),
    .zero_o (cnt_zero)
  );

  // line activity and bus drive, decoded from registered state
  logic [LN_COUNT-1:0] act, pins;
  logic                adr_phase, data_phase;

  always_comb begin
    adr_phase  = (state_q == ST_AHOLD) || (state_q == ST_ASETUP);
    data_phase = (state_q == ST_SETUP) || (state_q == ST_STROBE) || (state_q == ST_HOLD);
    act         = '0;
    act[LN_ALE] = (state_q == ST_ASETUP);
    act[LN_RE]  = (state_q == ST_STROBE) && !wr_q;
    act[LN_WE]  = (state_q == ST_STROBE) && wr_q;
    act[LN_CS]  = adr_phase || data_phase;
    bus_oe_o    = adr_phase || (data_phase && wr_q);
    if (adr_phase)
      bus_ad_o = mode16_q ? BW'(addr_q[MAW-1:0]) : BW'(addr_q);
    else if (data_phase && wr_q)
      bus_ad_o = mode16_q ? BW'(wdata_q) : BW'(wdata_q[NW-1:0]);
    else
      bus_ad_o = '0;
    bus_addr_o = (act[LN_CS] && !mux_q) ? addr_q[NW-1:0] : '0;
  end

  membus_pol #(.N(LN_COUNT)) u_pol (
    .act_i (act),
    .pol_i (cfg_pol_i),
    .pin_o (pins)
  );

  assign bus_ale_o   = pins[LN_ALE];
  assign bus_re_o    = pins[LN_RE];
  assign bus_we_o    = pins[LN_WE];
  assign bus_cs_o    = pins[LN_CS];
  assign rsp_done_o  = (state_q == ST_DONE);
  assign rsp_rdata_o = rdata_q;

  // R7: completion is a single-cycle pulse
  a_r7_done_single: assert property (@(posedge clk) disable iff (!rst_s_n)
    rsp_done_o |=> !rsp_done_o);

  // R1: a request arriving while busy leaves the captured access untouched
  a_r1_busy_ignores_start: assert property (@(posedge clk) disable iff (!rst_s_n)
    (state_q != ST_IDLE && req_start_i) |=> $stable(addr_q));

  // R3: no latch strobe in the non-multiplexed mode
  a_r3_no_ale_nonmux: assert property (@(posedge clk) disable iff (!rst_s_n)
    (!mux_q) |-> !act[LN_ALE]);

  // R9: bus released whenever the read strobe pin is active
  a_r9_read_released: assert property (@(posedge clk) disable iff (!rst_s_n)
    (bus_re_o == cfg_pol_i[LN_RE]) |-> !bus_oe_o);

  // R9: read data only moves out of the strobe phase
  a_r9_rdata_hold: assert property (@(posedge clk) disable iff (!rst_s_n)
    (state_q != ST_STROBE) |=> $stable(rsp_rdata_o));

endmodule

// File: tb/membus_seq_tb.sv
`timescale 1ns/1ps
module membus_seq_tb_top;

  localparam logic [23:0] RD_BASE = 24'hA53C96;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_start_i = 1'b0, req_write_i = 1'b0;
  logic [23:0] req_addr_i = '0;
  logic [15:0] req_wdata_i = '0;
  logic        rsp_done_o;
  logic [15:0] rsp_rdata_o;
  logic [1:0]  cfg_mode_i = '0;
  logic [3:0]  cfg_pol_i = '0;
  logic [1:0]  cfg_adr_hold_i = '0, cfg_adr_setup_i = '0;
  logic [1:0]  cfg_rd_setup_i = '0, cfg_rd_hold_i = '0, cfg_wr_setup_i = '0, cfg_wr_hold_i = '0;
  logic [3:0]  cfg_rd_strobe_i = '0, cfg_wr_strobe_i = '0;
  logic [23:0] bus_ad_o;
  logic [15:0] bus_ad_i = '0;
  logic        bus_oe_o;
  logic [7:0]  bus_addr_o;
  logic        bus_ale_o, bus_re_o, bus_we_o, bus_cs_o;

  int cyc = 0;
  int n_chk = 0;
  int n_fail = 0;
  bit finished = 0;

  always #5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;
  always @(negedge clk) bus_ad_i <= RD_BASE[15:0] ^ 16'(cyc);

  membus_seq dut_i (.*);

  typedef struct {
    int          at;
    logic [3:0]  pins;
    logic        oe;
    logic        chk_ad;
    logic [23:0] ad;
    logic        done;
    logic [7:0]  na;
    logic        chk_rd;
    logic [15:0] rd;
    string       tag;
  } item_t;

  item_t sb[$];

  // phase codes: 1 addr-hold, 2 addr-setup, 3 setup, 4 strobe, 5 hold, 6 done, 7 after
  task automatic push_ph(int at, int ph, bit wr, logic [1:0] mode, logic [23:0] addr,
                         logic [15:0] wd, logic [3:0] pol, logic [15:0] rdexp, string tag);
    item_t it;
    logic [3:0] act;
    act[0] = (ph == 2);
    act[1] = (ph == 4) && !wr;
    act[2] = (ph == 4) && wr;
    act[3] = (ph >= 1) && (ph <= 5);
    for (int i = 0; i < 4; i++) it.pins[i] = pol[i] ? act[i] : !act[i];
    it.at     = at;
    it.oe     = (ph == 1) || (ph == 2) || (wr && ph >= 3 && ph <= 5);
    it.chk_ad = it.oe;
    if (ph <= 2) it.ad = (mode == 2'd1) ? {8'h00, addr[15:0]} : addr;
    else         it.ad = (mode == 2'd1) ? {8'h00, wd} : {16'h0000, wd[7:0]};
    it.done   = (ph == 6);
    it.na     = (act[3] && mode == 2'd0) ? addr[7:0] : 8'h00;
    it.chk_rd = !wr && ph >= 6;
    it.rd     = rdexp;
    it.tag    = {tag, " R10"};
    sb.push_back(it);
  endtask

  task automatic access(bit wr, logic [1:0] mode, logic [23:0] addr, logic [15:0] wd,
                        logic [1:0] ah, logic [1:0] as, logic [1:0] su, logic [3:0] st,
                        logic [1:0] ho, logic [3:0] pol, bit poke);
    int t0, k, dah, das, dst, last;
    logic [15:0] rdexp, raw;
    bit mux;
    @(posedge clk); #2;
    cfg_mode_i = mode; cfg_pol_i = pol;
    cfg_adr_hold_i = ah; cfg_adr_setup_i = as;
    // the other direction gets different counts so a wrong selection shows
    if (wr) begin
      cfg_wr_setup_i = su; cfg_wr_strobe_i = st; cfg_wr_hold_i = ho;
      cfg_rd_setup_i = su + 2'd1; cfg_rd_strobe_i = st + 4'd3; cfg_rd_hold_i = ho + 2'd1;
    end else begin
      cfg_rd_setup_i = su; cfg_rd_strobe_i = st; cfg_rd_hold_i = ho;
      cfg_wr_setup_i = su + 2'd1; cfg_wr_strobe_i = st + 4'd3; cfg_wr_hold_i = ho + 2'd1;
    end
    req_write_i = wr; req_addr_i = addr; req_wdata_i = wd; req_start_i = 1'b1;
    t0  = cyc + 1;
    mux = (mode != 2'd0);
    dah = mux ? ((ah == 0) ? 1 : int'(ah)) : 0;
    das = mux ? int'(as) + 1 : 0;
    dst = (st == 0) ? 1 : int'(st);
    last = t0 + dah + das + int'(su) + dst - 1;
    raw  = RD_BASE[15:0] ^ 16'(last);
    rdexp = (mode == 2'd1) ? raw : {8'h00, raw[7:0]};
    k = 0;
    for (int i = 0; i < dah; i++) begin push_ph(t0 + k, 1, wr, mode, addr, wd, pol, rdexp, poke ? "R2 R1" : "R2"); k++; end
    for (int i = 0; i < das; i++) begin push_ph(t0 + k, 2, wr, mode, addr, wd, pol, rdexp, poke ? "R2 R1" : "R2"); k++; end
    for (int i = 0; i < int'(su); i++) begin push_ph(t0 + k, 3, wr, mode, addr, wd, pol, rdexp, wr ? "R4 R8" : "R4 R9"); k++; end
    for (int i = 0; i < dst; i++) begin push_ph(t0 + k, 4, wr, mode, addr, wd, pol, rdexp, wr ? "R5 R8" : "R5 R9"); k++; end
    for (int i = 0; i < int'(ho); i++) begin push_ph(t0 + k, 5, wr, mode, addr, wd, pol, rdexp, wr ? "R6 R8" : "R6"); k++; end
    push_ph(t0 + k, 6, wr, mode, addr, wd, pol, rdexp, mode == 2'd0 ? "R7 R3" : "R7"); k++;
    push_ph(t0 + k, 7, wr, mode, addr, wd, pol, rdexp, poke ? "R9 R1" : "R9"); k++;
    @(posedge clk); #2;
    req_start_i = 1'b0;
    if (poke) begin
      @(posedge clk); #2;
      req_start_i = 1'b1; req_write_i = !wr; req_addr_i = ~addr; req_wdata_i = ~wd;
      @(posedge clk); #2;
      req_start_i = 1'b0;
    end
    while (cyc <= t0 + k) @(posedge clk);
  endtask

  // scoreboard monitor: compares each expected cycle at its falling edge
  initial begin
    forever begin
      @(negedge clk);
      while (sb.size() > 0 && sb[0].at <= cyc) begin
        item_t e;
        logic [3:0] gp;
        bit ok;
        e  = sb.pop_front();
        gp = {bus_cs_o, bus_we_o, bus_re_o, bus_ale_o};
        ok = (e.at == cyc) && (gp == e.pins) && (bus_oe_o == e.oe) && (rsp_done_o == e.done)
             && (bus_addr_o == e.na) && (!e.chk_ad || bus_ad_o == e.ad)
             && (!e.chk_rd || rsp_rdata_o == e.rd);
        n_chk++;
        if (!ok) begin
          n_fail++;
          $display("FAIL %s cycle %0d: got pins=%b oe=%b ad=%h done=%b na=%h rd=%h, expected pins=%b oe=%b ad=%h done=%b na=%h rd=%h",
                   e.tag, e.at, gp, bus_oe_o, bus_ad_o, rsp_done_o, bus_addr_o, rsp_rdata_o,
                   e.pins, e.oe, e.ad, e.done, e.na, e.rd);
        end
      end
    end
  end

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog: got run still active, expected completion");
    finish_run();
  end

  initial begin
    repeat (3) @(posedge clk);
    #2 rst_n = 1'b1;
    repeat (5) @(posedge clk);
    @(negedge clk);
    // R11: reset state with all polarities active-low
    n_chk++;
    if ({bus_cs_o, bus_we_o, bus_re_o, bus_ale_o} !== 4'b1111 || bus_oe_o !== 1'b0 ||
        rsp_done_o !== 1'b0 || rsp_rdata_o !== 16'h0 || bus_addr_o !== 8'h0) begin
      n_fail++;
      $display("FAIL R11 reset: got pins=%b oe=%b done=%b rd=%h na=%h, expected pins=1111 oe=0 done=0 rd=0000 na=00",
               {bus_cs_o, bus_we_o, bus_re_o, bus_ale_o}, bus_oe_o, rsp_done_o, rsp_rdata_o, bus_addr_o);
    end
    //      wr  mode   addr        wdata     ah    as    su    st     ho    pol      poke
    access(0, 2'd1, 24'h12_3456, 16'h0000, 2'd0, 2'd0, 2'd1, 4'd0,  2'd2, 4'b0000, 0);
    access(1, 2'd1, 24'hAB_CDEF, 16'hBEEF, 2'd2, 2'd3, 2'd3, 4'd15, 2'd3, 4'b1111, 0);
    access(1, 2'd0, 24'h00_00C7, 16'h5A3C, 2'd1, 2'd2, 2'd0, 4'd0,  2'd0, 4'b1010, 0);
    access(0, 2'd2, 24'hF0_0F5A, 16'h0000, 2'd3, 2'd1, 2'd0, 4'd5,  2'd0, 4'b0101, 0);
    access(0, 2'd0, 24'h00_0033, 16'h0000, 2'd0, 2'd0, 2'd3, 4'd2,  2'd1, 4'b1001, 0);
    access(1, 2'd2, 24'h76_5432, 16'h1234, 2'd1, 2'd0, 2'd2, 4'd3,  2'd1, 4'b0110, 1);
    access(0, 2'd1, 24'h9C_8D7E, 16'h0000, 2'd2, 2'd0, 2'd1, 4'd4,  2'd2, 4'b0000, 1);
    access(0, 2'd3, 24'h3E_2D1C, 16'h0000, 2'd0, 2'd2, 2'd2, 4'd1,  2'd3, 4'b1100, 0);
    repeat (3) @(posedge clk);
    finish_run();
  end

endmodule